// File: doc/BRIEF.md
# Track Candidate Sorter with Duplicate Cancellation

The block takes nine muon track candidates per bunch crossing. They arrive as three streams of three tracks each. Streams 0 and 1 are keyed on station 2 and stream 2 is keyed on station 3. Each candidate carries:

- a 6-bit rank,
- a 9-bit hit identifier,
- a 4-bit mode code,
- a 4-bit per-station crossing tag.

Some candidates are the same muon found more than once because they reuse segments. Every pair of candidates is compared for shared segments. Where two candidates overlap, the weaker one is cancelled. From the survivors, the three with the highest rank are placed into output slots 0, 1 and 2, best first.

For each slot the block outputs three things. The first is a 17-bit segment descriptor. The second is the winner's crossing tag. The third is the winner's mode code.

All decisions are combinational. A single output register stage follows them, so a new set of candidates appears at the outputs one clock after it is applied.

Top module: `trk_sorter`

## Requirements
- R1: While rst_ni is low, every output is zero. This holds as soon as reset is asserted, without waiting for a clock.
- R2: Outputs change only on a rising clock edge. After each edge they reflect the inputs present just before that edge.
- R3: A candidate with mode 0 is empty. It is never selected and it cancels no other candidate.
- R4: The hit identifier holds three 3-bit fields. Field f sits in bits [3f+2:3f], and a field value of 0 means no segment. Two candidates share a segment when some field holds the same nonzero value in both. A valid candidate with fewer nonzero fields is cancelled by a valid sharing candidate with more nonzero fields, whatever their ranks.
- R5: Two sharing valid candidates may have the same number of nonzero fields. In that case the higher rank is kept. If the ranks are also equal, the lower index is kept, where index = stream*3 + track.
- R6: A cancelled candidate is never selected.
- R7: Slots 0, 1 and 2 hold the surviving candidates of highest, second and third rank. Equal ranks are ordered by lower index first.
- R8: A slot with no candidate has mode, crossing tag and descriptor all zero. Slots fill from slot 0 upward.
- R9: The descriptor is laid out as follows.
  - Bits [5f+4:5f] are segment number f. It is zero when field f is zero. Otherwise it is {key code, field value}, where the key code is 2'd1 for streams 0 and 1 and 2'd2 for stream 2.
  - Bit 15 is set when all three fields are nonzero.
  - Bit 16 is set when the mode code is 11 or more.
- R10: Each slot passes the winner's mode code and crossing tag through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rank_i | input | 54 | Rank of candidate i in bits [6i+5:6i] |
| hits_i | input | 81 | Hit identifier of candidate i in bits [9i+8:9i] |
| mode_i | input | 36 | Mode code of candidate i in bits [4i+3:4i]; 0 marks an empty candidate |
| bx_i | input | 36 | Crossing tag of candidate i in bits [4i+3:4i] |
| desc_o | output | 51 | Descriptor of slot k in bits [17k+16:17k] |
| bx_o | output | 12 | Crossing tag of slot k in bits [4k+3:4k] |
| mode_o | output | 12 | Mode code of slot k in bits [4k+3:4k] |

## Verification
The assertions take for granted that every input is at a known value at each rising edge once reset is released. Under that condition, the following hold for any input pattern, because the cancellation order and the rank order are both total orders:

- no two sharing candidates survive together;
- each slot picks at most one candidate;
- slots are filled in falling rank order.

The stimulus keeps inputs at zero throughout reset. It changes inputs only on falling edges. It covers distinct ranks, fully tied ranks, empty sets, partly empty sets, cancellation by length, cancellation by rank and by index, and an empty candidate that overlaps a valid one.

// File: rtl/trk_sort_pkg.sv
package trk_sort_pkg;
  localparam int RANK_W = 6;
  localparam int SEG_W  = 3;
  localparam int N_FLD  = 3;
  localparam int MODE_W = 4;
  localparam int BX_W   = 4;
  localparam int KEY_W  = 2;
  localparam int HIT_W  = N_FLD * SEG_W;
  localparam int SEGN_W = KEY_W + SEG_W;
  localparam int DESC_W = N_FLD * SEGN_W + 2;
  localparam int SLOT_W = MODE_W + BX_W + DESC_W;
  localparam int LEN_W  = $clog2(N_FLD + 1);

  localparam logic [MODE_W-1:0] OVL_MODE = MODE_W'(11);
  localparam logic [KEY_W-1:0]  KEY_ST2  = KEY_W'(1);
  localparam logic [KEY_W-1:0]  KEY_ST3  = KEY_W'(2);

  function automatic logic [LEN_W-1:0] seg_len(input logic [HIT_W-1:0] h);
    logic [LEN_W-1:0] n;
    n = '0;
    for (int f = 0; f < N_FLD; f++)
      if (h[f*SEG_W +: SEG_W] != '0) n = n + LEN_W'(1);
    return n;
  endfunction

  function automatic logic hits_overlap(input logic [HIT_W-1:0] a,
                                        input logic [HIT_W-1:0] b);
    logic s;
    s = 1'b0;
    for (int f = 0; f < N_FLD; f++)
      if (a[f*SEG_W +: SEG_W] != '0 && a[f*SEG_W +: SEG_W] == b[f*SEG_W +: SEG_W])
        s = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/trk_cancel.sv
module trk_cancel
  import trk_sort_pkg::*;
#(
  parameter int N = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N*RANK_W-1:0] rank_i,
  input  logic [N*HIT_W-1:0]  hits_i,
  input  logic [N-1:0]        valid_i,
  output logic [N-1:0]        alive_o
);
  logic [RANK_W-1:0] rk  [N];
  logic [HIT_W-1:0]  ht  [N];
  logic [LEN_W-1:0]  len [N];
  logic [N-1:0]      shr [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign rk[i]  = rank_i[i*RANK_W +: RANK_W];
    assign ht[i]  = hits_i[i*HIT_W +: HIT_W];
    assign len[i] = seg_len(ht[i]);
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        shr[i][j] = (i != j) && hits_overlap(ht[i], ht[j]);
  end

  // j beats i: longer first, then rank, then lower index
  always_comb begin
    logic kill;
    for (int i = 0; i < N; i++) begin
      kill = 1'b0;
      for (int j = 0; j < N; j++)
        if (valid_i[j] && shr[i][j] &&
            (len[j] > len[i] ||
             (len[j] == len[i] && (rk[j] > rk[i] || (rk[j] == rk[i] && j < i)))))
          kill = 1'b1;
      alive_o[i] = valid_i[i] && !kill;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk_i
    for (genvar j = i + 1; j < N; j++) begin : g_chk_j
      p_alive_disjoint_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(alive_o[i] && alive_o[j] && shr[i][j]));
    end
  end
endmodule

// File: rtl/trk_rank_sel.sv
module trk_rank_sel
  import trk_sort_pkg::*;
#(
  parameter int N     = 9,
  parameter int N_SEL = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N*RANK_W-1:0]        rank_i,
  input  logic [N-1:0]               alive_i,
  output logic [N_SEL-1:0][N-1:0]    sel_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic [RANK_W-1:0] rk  [N];
  logic [CNT_W-1:0]  pos [N];
  logic [RANK_W-1:0] sel_rk [N_SEL];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign rk[i] = rank_i[i*RANK_W +: RANK_W];
  end

  // position = number of survivors ordered ahead of candidate i
  always_comb begin
    for (int i = 0; i < N; i++) begin
      pos[i] = '0;
      for (int j = 0; j < N; j++)
        if (j != i && alive_i[j] && (rk[j] > rk[i] || (rk[j] == rk[i] && j < i)))
          pos[i] = pos[i] + CNT_W'(1);
    end
  end

  always_comb begin
    for (int k = 0; k < N_SEL; k++) begin
      sel_rk[k] = '0;
      for (int i = 0; i < N; i++) begin
        sel_o[k][i] = alive_i[i] && (pos[i] == CNT_W'(k));
        if (sel_o[k][i]) sel_rk[k] = sel_rk[k] | rk[i];
      end
    end
  end

  for (genvar k = 0; k < N_SEL; k++) begin : g_chk
    p_slot_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_o[k]));
    if (k > 0) begin : g_ord
      p_rank_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o[k] != '0) |-> (sel_o[k-1] != '0 && sel_rk[k-1] >= sel_rk[k]));
    end
  end
endmodule

// File: rtl/trk_pack.sv
module trk_pack
  import trk_sort_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = KEY_ST2
) (
  input  logic [HIT_W-1:0]  hits_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [DESC_W-1:0] desc_o
);
  always_comb begin
    logic all_set;
    all_set = 1'b1;
    desc_o  = '0;
    for (int f = 0; f < N_FLD; f++) begin
      if (hits_i[f*SEG_W +: SEG_W] == '0) all_set = 1'b0;
      else desc_o[f*SEGN_W +: SEGN_W] = {KEY, hits_i[f*SEG_W +: SEG_W]};
    end
    desc_o[DESC_W-2] = all_set;
    desc_o[DESC_W-1] = (mode_i >= OVL_MODE);
  end
endmodule

// File: rtl/trk_sorter.sv
module trk_sorter
  import trk_sort_pkg::*;
#(
  parameter int N_STREAM = 3,
  parameter int N_TRK    = 3,
  parameter int N_SEL    = 3
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [N_STREAM*N_TRK*RANK_W-1:0]        rank_i,
  input  logic [N_STREAM*N_TRK*HIT_W-1:0]         hits_i,
  input  logic [N_STREAM*N_TRK*MODE_W-1:0]        mode_i,
  input  logic [N_STREAM*N_TRK*BX_W-1:0]          bx_i,
  output logic [N_SEL*DESC_W-1:0]                 desc_o,
  output logic [N_SEL*BX_W-1:0]                   bx_o,
  output logic [N_SEL*MODE_W-1:0]                 mode_o
);
  localparam int N = N_STREAM * N_TRK;

  logic [N-1:0]              valid, alive;
  logic [N_SEL-1:0][N-1:0]   sel;
  logic [SLOT_W-1:0]         cand_w [N];
  logic [N_SEL-1:0][SLOT_W-1:0] slot_d, slot_q;

  for (genvar i = 0; i < N; i++) begin : g_cand
    logic [DESC_W-1:0] desc;
    assign valid[i] = mode_i[i*MODE_W +: MODE_W] != '0;
    trk_pack #(
      .KEY((i / N_TRK == N_STREAM - 1) ? KEY_ST3 : KEY_ST2)
    ) u_pack (
      .hits_i (hits_i[i*HIT_W +: HIT_W]),
      .mode_i (mode_i[i*MODE_W +: MODE_W]),
      .desc_o (desc)
    );
    assign cand_w[i] = {mode_i[i*MODE_W +: MODE_W], bx_i[i*BX_W +: BX_W], desc};
  end

  trk_cancel #(.N(N)) u_cancel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rank_i  (rank_i),
    .hits_i  (hits_i),
    .valid_i (valid),
    .alive_o (alive)
  );

  trk_rank_sel #(.N(N), .N_SEL(N_SEL)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rank_i  (rank_i),
    .alive_i (alive),
    .sel_o   (sel)
  );

  always_comb begin
    for (int k = 0; k < N_SEL; k++) begin
      slot_d[k] = '0;
      for (int i = 0; i < N; i++)
        if (sel[k][i]) slot_d[k] = slot_d[k] | cand_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  for (genvar k = 0; k < N_SEL; k++) begin : g_out
    assign mode_o[k*MODE_W +: MODE_W] = slot_q[k][SLOT_W-1 -: MODE_W];
    assign bx_o[k*BX_W +: BX_W]       = slot_q[k][DESC_W +: BX_W];
    assign desc_o[k*DESC_W +: DESC_W] = slot_q[k][DESC_W-1:0];

    p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o[k*MODE_W +: MODE_W] == '0) |->
        (desc_o[k*DESC_W +: DESC_W] == '0 && bx_o[k*BX_W +: BX_W] == '0));
    if (k > 0) begin : g_fill
      p_fill_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o[k*MODE_W +: MODE_W] != '0) |-> (mode_o[(k-1)*MODE_W +: MODE_W] != '0));
    end
  end
endmodule

// File: tb/sim_trk_sorter.sv
module sim_trk_sorter;
  typedef struct packed {
    logic [8:0][5:0] rk;
    logic [8:0][8:0] ht;
    logic [8:0][3:0] md;
    logic [2:0][3:0] ex;   // expected candidate index per slot, 15 = empty
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    // 0: distinct ranks, no sharing, overlap mode on c4
    '{rk: {6'd2,6'd1,6'd40,6'd5,6'd60,6'd20,6'd30,6'd50,6'd10},
      ht: {9'o200,9'o100,9'o077,9'o066,9'o055,9'o044,9'o033,9'o022,9'o011},
      md: {4'd10,4'd9,4'd8,4'd7,4'd12,4'd5,4'd4,4'd3,4'd2},
      ex: {4'd6,4'd1,4'd4}},
    // 1: all ranks equal
    '{rk: {9{6'd7}},
      ht: {9'o200,9'o100,9'o077,9'o066,9'o055,9'o044,9'o033,9'o022,9'o011},
      md: {4'd10,4'd9,4'd8,4'd7,4'd6,4'd5,4'd4,4'd3,4'd2},
      ex: {4'd2,4'd1,4'd0}},
    // 2: nothing valid
    '{rk: {6'd2,6'd1,6'd40,6'd5,6'd60,6'd20,6'd30,6'd50,6'd10},
      ht: {9'o200,9'o100,9'o077,9'o066,9'o055,9'o044,9'o033,9'o022,9'o011},
      md: {9{4'd0}},
      ex: {4'd15,4'd15,4'd15}},
    // 3: two valid
    '{rk: {6'd9,6'd50,6'd50,6'd3,6'd50,6'd50,6'd50,6'd50,6'd50},
      ht: {9'o200,9'o100,9'o077,9'o066,9'o055,9'o044,9'o033,9'o022,9'o011},
      md: {4'd10,4'd0,4'd0,4'd7,4'd0,4'd0,4'd0,4'd0,4'd0},
      ex: {4'd15,4'd5,4'd8}},
    // 4: longer c0 cancels higher-ranked c1
    '{rk: {6'd63,6'd63,6'd63,6'd2,6'd30,6'd20,6'd10,6'd60,6'd31},
      ht: {9'o000,9'o000,9'o000,9'o077,9'o066,9'o055,9'o044,9'o020,9'o123},
      md: {4'd0,4'd0,4'd0,4'd7,4'd6,4'd5,4'd4,4'd3,4'd2},
      ex: {4'd3,4'd4,4'd0}},
    // 5: equal length: rank decides c0/c1, index decides c2/c3
    '{rk: {6'd63,6'd63,6'd63,6'd63,6'd63,6'd45,6'd45,6'd50,6'd40},
      ht: {9'o000,9'o000,9'o000,9'o000,9'o000,9'o034,9'o033,9'o012,9'o011},
      md: {4'd0,4'd0,4'd0,4'd0,4'd0,4'd5,4'd4,4'd3,4'd2},
      ex: {4'd15,4'd2,4'd1}},
    // 6: empty c0 overlaps c1 but does not cancel it
    '{rk: {6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd4,6'd5,6'd63},
      ht: {9'o000,9'o000,9'o000,9'o000,9'o000,9'o000,9'o022,9'o011,9'o111},
      md: {4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd4,4'd3,4'd0},
      ex: {4'd15,4'd2,4'd1}},
    // 7: same with c0 valid: c1 cancelled
    '{rk: {6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd4,6'd5,6'd63},
      ht: {9'o000,9'o000,9'o000,9'o000,9'o000,9'o000,9'o022,9'o011,9'o111},
      md: {4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd4,4'd3,4'd2},
      ex: {4'd15,4'd2,4'd0}}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [53:0] rank_i;
  logic [80:0] hits_i;
  logic [35:0] mode_i;
  logic [35:0] bx_i;
  logic [50:0] desc_o;
  logic [11:0] bx_o;
  logic [11:0] mode_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  trk_sorter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rank_i(rank_i), .hits_i(hits_i),
    .mode_i(mode_i), .bx_i(bx_i), .desc_o(desc_o), .bx_o(bx_o), .mode_o(mode_o)
  );

  function automatic logic [24:0] exp_slot(input vec_t v, input int k);
    int idx;
    logic [16:0] d;
    logic [3:0]  m;
    logic [2:0]  h;
    logic [1:0]  key;
    bit three;
    idx = int'(v.ex[k]);
    if (idx == 15) return '0;
    m = v.md[idx];
    key = (idx / 3 == 2) ? 2'd2 : 2'd1;
    d = '0;
    three = 1'b1;
    for (int f = 0; f < 3; f++) begin
      h = v.ht[idx][f*3 +: 3];
      if (h == 3'd0) three = 1'b0;
      else d[f*5 +: 5] = {key, h};
    end
    d[15] = three;
    d[16] = (m >= 4'd11);
    return {m, 4'(15 - idx), d};
  endfunction

  function automatic string row_req(input int r);
    case (r)
      0: return "R7 R9 R10";
      1: return "R7 R9";
      2: return "R3 R8";
      3: return "R7 R8";
      4: return "R4 R6 R9";
      5: return "R5 R6";
      6: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input int row, input string tag, input string req);
    logic [24:0] got, exp;
    for (int k = 0; k < 3; k++) begin
      exp = (row < 0) ? 25'd0 : exp_slot(TBL[row], k);
      got = {mode_o[k*4 +: 4], bx_o[k*4 +: 4], desc_o[k*17 +: 17]};
      n_chk++;
      if (got !== exp) begin
        n_fail++;
        $display("FAIL %s %s slot %0d: got %h exp %h", req, tag, k, got, exp);
      end
    end
  endtask

  task automatic apply(input int r);
    rank_i = TBL[r].rk;
    hits_i = TBL[r].ht;
    mode_i = TBL[r].md;
  endtask

  initial begin
    rst_ni = 1'b0;
    rank_i = '0;
    hits_i = '0;
    mode_i = '0;
    for (int i = 0; i < 9; i++) bx_i[i*4 +: 4] = 4'(15 - i);
    repeat (3) @(negedge clk_i);
    chk(-1, "held in reset", "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(-1, "after release, no candidates", "R1 R8");

    for (int r = 0; r < NV; r++) begin
      apply(r);
      #1;
      chk(r - 1, $sformatf("row %0d before edge", r), "R2");
      @(negedge clk_i);
      chk(r, $sformatf("row %0d", r), row_req(r));
    end

    // asynchronous reset with live outputs, then hold across an edge
    rst_ni = 1'b0;
    #1;
    chk(-1, "async assert", "R1");
    @(negedge clk_i);
    chk(-1, "edge during reset", "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(NV - 1, "first edge after release", "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: got hang exp finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule